// File: doc/BRIEF.md
# Calendar Clock Register Counter

This block holds the time and date of a calendar clock as a set of byte registers: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-second update strobe advances the count. Carries ripple from seconds through minutes, hours and days into months and years. Day-of-month rollover follows the calendar month lengths, and February gets a 29th day in leap years.

A control byte sets how the values are held. The encoding is either packed BCD or plain binary. Hours are kept either on a 24-hour dial or on a 12-hour dial with a PM flag. The same control byte has a freeze bit that stops the count while software loads a new time. Software reaches every register through a single synchronous write port and a combinational read port that share one address. The mode bits do not convert values that are already stored, so software reloads the time after it changes the mode.

Top module: `calendar_clock`

## Requirements
- R1: After reset the registers hold 00:00:00, day of week 1, day 1, month 1 and year 0. The control byte reads 0x02, which selects BCD and 24-hour format.
- R2: The address map is seconds at 0, minutes at 2, hours at 4, day of week at 6, day of month at 7, month at 8, year at 9 and control at 11. A write stores the byte and a read returns it. Every other offset reads 0x00, and a write to such an offset changes nothing.
- R3: With control bit 2 clear, the values are packed BCD and every digit carries decimally. For example, seconds 0x09 step to 0x10, and 0x59 steps to 0x00 and carries into the minutes.
- R4: With control bit 2 set, the values are binary and count over the same ranges. For example, seconds 59 step to 0 and carry.
- R5: With control bit 1 set (24-hour format), the hour counts 0 to 23. Stepping from hour 23 wraps it to 0 and advances the day.
- R6: With control bit 1 clear (12-hour format), the hour counts 1 to 12 and bit 7 of the hour byte is the PM flag. Midnight is 12 with the flag clear and noon is 12 with the flag set. Stepping 11 AM gives 12 PM and 12 PM gives 1 PM. Stepping 11 PM gives 12 AM and advances the day.
- R7: Day of week (1 to 7, with 1 meaning Sunday) advances on every day rollover and wraps from 7 to 1.
- R8: Day of month wraps to 1 and the month advances after day 30 in April, June, September and November and after day 31 in the other long months. In February the wrap comes after day 28, or after day 29 when the year is a multiple of 4.
- R9: Month 12 wraps to 1 and advances the year, and year 99 wraps to 0.
- R10: While control bit 7 is set, update strobes are ignored and no time register changes.
- R11: An update strobe that arrives in the same cycle as a register write is dropped. Only the write takes effect.
- R12: An accepted strobe is visible on the read port from the first clock edge after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second update strobe, one cycle wide |
| wrEn | input | 1 | Register write enable |
| addr | input | 4 | Register offset for write and read |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |

## Verification
A wrong carry decision shows up on the read port in the cycle right after the strobe that causes it. Examples are a missed BCD digit carry, a wrong month length or a misplaced 12-hour PM transition. The field itself shows an out-of-range digit or value, or a higher field fails to move. Loaded times are biased toward the last second before each rollover, so every carry path is exercised within a few strobes. A wrong freeze or collision decision shows at once as a seconds value that moved when it should have held.

// File: rtl/calendar_pkg.sv
package calendar_pkg;

  localparam int ByteW   = 8;
  localparam int ValW    = 7;

  localparam int OffSec  = 0;
  localparam int OffMin  = 2;
  localparam int OffHour = 4;
  localparam int OffWday = 6;
  localparam int OffMday = 7;
  localparam int OffMon  = 8;
  localparam int OffYear = 9;
  localparam int OffCtrl = 11;

  localparam int CtrlFreezeBit = 7;
  localparam int CtrlBinBit    = 2;
  localparam int Ctrl24Bit     = 1;

  localparam logic [ByteW-1:0] CtrlResetVal = 8'h02;

  typedef struct packed {
    logic stepSec;
    logic stepMin;
    logic stepHour;
    logic stepDay;
    logic stepMon;
    logic stepYear;
  } stepStrobes_t;

  // Byte to numeric value, for either encoding.
  function automatic logic [ValW-1:0] decodeVal(input logic [ByteW-1:0] v, input logic bin);
    logic [ByteW-1:0] t;
    t = {4'd0, v[7:4]} * 8'd10 + {4'd0, v[3:0]};
    return bin ? v[ValW-1:0] : t[ValW-1:0];
  endfunction

  // Numeric value (0..99) to byte, for either encoding.
  function automatic logic [ByteW-1:0] encodeVal(input logic [ValW-1:0] n, input logic bin);
    logic [ValW-1:0] tn;
    logic [ValW-1:0] on;
    tn = n / 7'd10;
    on = n - tn * 7'd10;
    return bin ? {1'b0, n} : {tn[3:0], on[3:0]};
  endfunction

endpackage

// File: rtl/calendar_ctrl.sv
module calendar_ctrl
  import calendar_pkg::*;
(
  input  logic         tick,
  input  logic         wrEn,
  input  logic         frozen,
  input  logic         secMax,
  input  logic         minMax,
  input  logic         hourMax,
  input  logic         dayMax,
  input  logic         monMax,
  output stepStrobes_t stb
);

  logic accept;

  // A write or a freeze swallows the strobe entirely.
  assign accept = tick && !wrEn && !frozen;

  always_comb begin
    stb.stepSec  = accept;
    stb.stepMin  = stb.stepSec  && secMax;
    stb.stepHour = stb.stepMin  && minMax;
    stb.stepDay  = stb.stepHour && hourMax;
    stb.stepMon  = stb.stepDay  && dayMax;
    stb.stepYear = stb.stepMon  && monMax;
  end

endmodule

// File: rtl/calendar_datapath.sv
module calendar_datapath
  import calendar_pkg::*;
#(
  parameter int AddrW = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [AddrW-1:0] addr,
  input  logic [ByteW-1:0] wrData,
  input  stepStrobes_t     stb,
  output logic [ByteW-1:0] rdData,
  output logic             frozen,
  output logic             binMode,
  output logic             hour24Mode,
  output logic             secMax,
  output logic             minMax,
  output logic             hourMax,
  output logic             dayMax,
  output logic             monMax,
  output logic [ByteW-1:0] secReg,
  output logic [ByteW-1:0] hourReg,
  output logic [ByteW-1:0] wdayReg
);

  localparam logic [AddrW-1:0] ASec  = AddrW'(OffSec);
  localparam logic [AddrW-1:0] AMin  = AddrW'(OffMin);
  localparam logic [AddrW-1:0] AHour = AddrW'(OffHour);
  localparam logic [AddrW-1:0] AWday = AddrW'(OffWday);
  localparam logic [AddrW-1:0] AMday = AddrW'(OffMday);
  localparam logic [AddrW-1:0] AMon  = AddrW'(OffMon);
  localparam logic [AddrW-1:0] AYear = AddrW'(OffYear);
  localparam logic [AddrW-1:0] ACtrl = AddrW'(OffCtrl);

  logic [ByteW-1:0] minReg, mdayReg, monReg, yearReg, ctrlReg;

  logic [ValW-1:0] secVal, minVal, wdayVal, mdayVal, monVal, yearVal;
  logic [ValW-1:0] h12Val, hour24Val, hourNext, monthLen;
  logic            pmFlag, leapYear;
  logic [ByteW-1:0] hourNextByte;

  assign frozen     = ctrlReg[CtrlFreezeBit];
  assign binMode    = ctrlReg[CtrlBinBit];
  assign hour24Mode = ctrlReg[Ctrl24Bit];

  // Decode the stored bytes into plain numbers
  always_comb begin
    secVal  = decodeVal(secReg,  binMode);
    minVal  = decodeVal(minReg,  binMode);
    wdayVal = decodeVal(wdayReg, binMode);
    mdayVal = decodeVal(mdayReg, binMode);
    monVal  = decodeVal(monReg,  binMode);
    yearVal = decodeVal(yearReg, binMode);
    h12Val  = decodeVal({1'b0, hourReg[6:0]}, binMode);
    pmFlag  = hourReg[7];
  end

  // Hour on a 0..23 scale, whatever the format
  always_comb begin
    if (hour24Mode) begin
      hour24Val = decodeVal(hourReg, binMode);
    end else if (h12Val == 7'd12) begin
      hour24Val = pmFlag ? 7'd12 : 7'd0;
    end else begin
      hour24Val = pmFlag ? h12Val + 7'd12 : h12Val;
    end
  end

  // Month length from month and leap year
  always_comb begin
    leapYear = (yearVal[1:0] == 2'b00);
    case (monVal)
      7'd2:                       monthLen = leapYear ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:    monthLen = 7'd30;
      default:                    monthLen = 7'd31;
    endcase
  end

  assign secMax  = secVal  >= 7'd59;
  assign minMax  = minVal  >= 7'd59;
  assign hourMax = hour24Val >= 7'd23;
  assign dayMax  = mdayVal >= monthLen;
  assign monMax  = monVal  >= 7'd12;

  // Next hour byte in the selected format
  always_comb begin
    hourNext = hourMax ? 7'd0 : hour24Val + 7'd1;
    if (hour24Mode) begin
      hourNextByte = encodeVal(hourNext, binMode);
    end else if (hourNext == 7'd0) begin
      hourNextByte = encodeVal(7'd12, binMode);
    end else if (hourNext < 7'd12) begin
      hourNextByte = encodeVal(hourNext, binMode);
    end else if (hourNext == 7'd12) begin
      hourNextByte = 8'h80 | encodeVal(7'd12, binMode);
    end else begin
      hourNextByte = 8'h80 | encodeVal(hourNext - 7'd12, binMode);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secReg  <= 8'h00;
      minReg  <= 8'h00;
      hourReg <= 8'h00;
      wdayReg <= 8'h01;
      mdayReg <= 8'h01;
      monReg  <= 8'h01;
      yearReg <= 8'h00;
      ctrlReg <= CtrlResetVal;
    end else if (wrEn) begin
      case (addr)
        ASec:    secReg  <= wrData;
        AMin:    minReg  <= wrData;
        AHour:   hourReg <= wrData;
        AWday:   wdayReg <= wrData;
        AMday:   mdayReg <= wrData;
        AMon:    monReg  <= wrData;
        AYear:   yearReg <= wrData;
        ACtrl:   ctrlReg <= wrData;
        default: ;
      endcase
    end else begin
      if (stb.stepSec)
        secReg <= secMax ? 8'h00 : encodeVal(secVal + 7'd1, binMode);
      if (stb.stepMin)
        minReg <= minMax ? 8'h00 : encodeVal(minVal + 7'd1, binMode);
      if (stb.stepHour)
        hourReg <= hourNextByte;
      if (stb.stepDay) begin
        wdayReg <= (wdayVal >= 7'd7) ? encodeVal(7'd1, binMode)
                                     : encodeVal(wdayVal + 7'd1, binMode);
        mdayReg <= dayMax ? encodeVal(7'd1, binMode)
                          : encodeVal(mdayVal + 7'd1, binMode);
      end
      if (stb.stepMon)
        monReg <= monMax ? encodeVal(7'd1, binMode)
                         : encodeVal(monVal + 7'd1, binMode);
      if (stb.stepYear)
        yearReg <= (yearVal >= 7'd99) ? 8'h00 : encodeVal(yearVal + 7'd1, binMode);
    end
  end

  always_comb begin
    case (addr)
      ASec:    rdData = secReg;
      AMin:    rdData = minReg;
      AHour:   rdData = hourReg;
      AWday:   rdData = wdayReg;
      AMday:   rdData = mdayReg;
      AMon:    rdData = monReg;
      AYear:   rdData = yearReg;
      ACtrl:   rdData = ctrlReg;
      default: rdData = 8'h00;
    endcase
  end

endmodule

// File: rtl/calendar_clock.sv
module calendar_clock
  import calendar_pkg::*;
#(
  parameter int AddrW = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             wrEn,
  input  logic [AddrW-1:0] addr,
  input  logic [ByteW-1:0] wrData,
  output logic [ByteW-1:0] rdData
);

  stepStrobes_t     stb;
  logic             frozen, binMode, hour24Mode;
  logic             secMax, minMax, hourMax, dayMax, monMax;
  logic [ByteW-1:0] secReg, hourReg, wdayReg;

  calendar_ctrl u_ctrl (
    .tick    (tick),
    .wrEn    (wrEn),
    .frozen  (frozen),
    .secMax  (secMax),
    .minMax  (minMax),
    .hourMax (hourMax),
    .dayMax  (dayMax),
    .monMax  (monMax),
    .stb     (stb)
  );

  calendar_datapath #(.AddrW(AddrW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .addr       (addr),
    .wrData     (wrData),
    .stb        (stb),
    .rdData     (rdData),
    .frozen     (frozen),
    .binMode    (binMode),
    .hour24Mode (hour24Mode),
    .secMax     (secMax),
    .minMax     (minMax),
    .hourMax    (hourMax),
    .dayMax     (dayMax),
    .monMax     (monMax),
    .secReg     (secReg),
    .hourReg    (hourReg),
    .wdayReg    (wdayReg)
  );

endmodule

// File: rtl/calendar_clock_checker.sv
module calendar_clock_checker
  import calendar_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic             wrEn,
  input stepStrobes_t     stb,
  input logic             frozen,
  input logic             binMode,
  input logic             hour24Mode,
  input logic             secMax,
  input logic [ByteW-1:0] secReg,
  input logic [ByteW-1:0] hourReg,
  input logic [ByteW-1:0] wdayReg
);

  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepSec && secMax) |=> (secReg == 8'h00));

  assert_bcd_digit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepSec && !binMode) |=> (secReg[3:0] <= 4'd9));

  assert_hour12_nonzero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepHour && !hour24Mode) |=> (hourReg[6:0] != 7'd0));

  assert_wday_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepDay |=> (wdayReg[6:0] != 7'd0 && wdayReg[6:0] <= 7'd7));

  assert_freeze_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && !wrEn) |=> ($stable(secReg) && $stable(hourReg) && $stable(wdayReg)));

  assert_write_drops_tick_R11: assert property (@(posedge clk) disable iff (!rstN)
    (tick && wrEn) |-> !stb.stepSec);

  assert_tick_visible_R12: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !wrEn && !frozen) |=> !$stable(secReg));

endmodule

bind calendar_clock calendar_clock_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .tick       (tick),
  .wrEn       (wrEn),
  .stb        (stb),
  .frozen     (frozen),
  .binMode    (binMode),
  .hour24Mode (hour24Mode),
  .secMax     (secMax),
  .secReg     (secReg),
  .hourReg    (hourReg),
  .wdayReg    (wdayReg)
);

// File: tb/calendar_clock_test.sv
`timescale 1ns/1ps
module calendar_clock_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  // expected model, plain numbers
  int mSec, mMin, mHr, mWday, mDay, mMon, mYear;
  bit mBin, m24;

  calendar_clock uut (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] enc(int v);
    if (mBin) return 8'(v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] hourByte();
    if (m24) return enc(mHr);
    if (mHr == 0) return enc(12);
    if (mHr < 12) return enc(mHr);
    if (mHr == 12) return 8'h80 | enc(12);
    return 8'h80 | enc(mHr - 12);
  endfunction

  function automatic int monLen(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic void advance();
    mSec++;
    if (mSec < 60) return;
    mSec = 0; mMin++;
    if (mMin < 60) return;
    mMin = 0; mHr++;
    if (mHr < 24) return;
    mHr = 0;
    mWday = (mWday == 7) ? 1 : mWday + 1;
    mDay++;
    if (mDay <= monLen(mMon, mYear)) return;
    mDay = 1; mMon++;
    if (mMon <= 12) return;
    mMon = 1;
    mYear = (mYear == 99) ? 0 : mYear + 1;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic writeReg(int a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = 4'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(int a, output logic [7:0] d);
    @(negedge clk);
    addr = 4'(a);
    #1 d = rdData;
  endtask

  task automatic doTick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  logic [7:0] ctrlVal;
  task automatic loadTime();
    ctrlVal = 8'((mBin ? 4 : 0) | (m24 ? 2 : 0));
    writeReg(11, ctrlVal | 8'h80);
    writeReg(0, enc(mSec));
    writeReg(2, enc(mMin));
    writeReg(4, hourByte());
    writeReg(6, enc(mWday));
    writeReg(7, enc(mDay));
    writeReg(8, enc(mMon));
    writeReg(9, enc(mYear));
    writeReg(11, ctrlVal);
  endtask

  task automatic checkAll(string req);
    logic [7:0] d;
    readReg(0, d); check(req, d, enc(mSec));
    readReg(2, d); check(req, d, enc(mMin));
    readReg(4, d); check(req, d, hourByte());
    readReg(6, d); check(req, d, enc(mWday));
    readReg(7, d); check(req, d, enc(mDay));
    readReg(8, d); check(req, d, enc(mMon));
    readReg(9, d); check(req, d, enc(mYear));
  endtask

  task automatic setModel(int s, int mi, int h, int w, int dy, int mo, int y);
    mSec = s; mMin = mi; mHr = h; mWday = w; mDay = dy; mMon = mo; mYear = y;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    mBin = 0; m24 = 1;
    setModel(0, 0, 0, 1, 1, 1, 0);
    checkAll("R1");
    readReg(11, d); check("R1 ctrl", d, 8'h02);

    // R2: unused offsets read zero and ignore writes
    writeReg(3, 8'h5A);
    readReg(3, d); check("R2 unused", d, 8'h00);
    readReg(1, d); check("R2 unused", d, 8'h00);
    checkAll("R2");

    // R3: BCD digit carry and R12 timing
    setModel(9, 0, 0, 1, 1, 1, 0);
    loadTime();
    doTick(); advance();
    readReg(0, d); check("R3 R12 0x09->0x10", d, 8'h10);
    setModel(59, 59, 9, 3, 15, 5, 10);
    loadTime();
    doTick(); advance();
    checkAll("R3 carry");

    // R4: binary mode carry
    mBin = 1; m24 = 1;
    setModel(59, 59, 23, 7, 30, 6, 45);
    loadTime();
    doTick(); advance();
    checkAll("R4 R5 R7");

    // R6: 12-hour transitions
    mBin = 0; m24 = 0;
    setModel(59, 59, 11, 2, 10, 3, 5);
    loadTime();
    doTick(); advance();
    readReg(4, d); check("R6 11AM->12PM", d, 8'h92);
    setModel(59, 59, 12, 2, 10, 3, 5);
    loadTime();
    doTick(); advance();
    readReg(4, d); check("R6 12PM->1PM", d, 8'h81);
    setModel(59, 59, 23, 7, 10, 3, 5);
    loadTime();
    doTick(); advance();
    readReg(4, d); check("R6 11PM->12AM", d, 8'h12);
    readReg(6, d); check("R7 wday wrap", d, 8'h01);
    checkAll("R6");

    // R8: February leap/non-leap
    mBin = 0; m24 = 1;
    setModel(59, 59, 23, 4, 28, 2, 23);
    loadTime(); doTick(); advance();
    readReg(7, d); check("R8 feb non-leap", d, 8'h01);
    readReg(8, d); check("R8 feb non-leap", d, 8'h03);
    setModel(59, 59, 23, 4, 28, 2, 24);
    loadTime(); doTick(); advance();
    readReg(7, d); check("R8 feb leap", d, 8'h29);
    setModel(59, 59, 23, 4, 30, 4, 24);
    loadTime(); doTick(); advance();
    checkAll("R8 april");

    // R9: year wrap
    setModel(59, 59, 23, 6, 31, 12, 99);
    loadTime(); doTick(); advance();
    checkAll("R9");
    readReg(9, d); check("R9 year 99->0", d, 8'h00);

    // R10: freeze ignores ticks
    setModel(30, 10, 5, 2, 3, 4, 20);
    loadTime();
    writeReg(11, 8'h82);
    doTick(); doTick();
    checkAll("R10 frozen");
    writeReg(11, 8'h02);

    // R11: write and tick in same cycle
    @(negedge clk);
    wrEn = 1'b1; tick = 1'b1; addr = 4'd9; wrData = enc(mYear);
    @(negedge clk);
    wrEn = 1'b0; tick = 1'b0;
    checkAll("R11 collision");

    // Random trials near rollovers
    for (int t = 0; t < 60; t++) begin
      mBin = 1'($urandom_range(0, 1));
      m24  = 1'($urandom_range(0, 1));
      mYear = $urandom_range(0, 99);
      mMon  = $urandom_range(1, 12);
      mDay  = monLen(mMon, mYear) - $urandom_range(0, 1);
      setModel($urandom_range(55, 59), $urandom_range(58, 59), $urandom_range(0, 23),
               $urandom_range(1, 7), mDay, mMon, mYear);
      if ($urandom_range(0, 1) == 1) mHr = $urandom_range(22, 23);
      loadTime();
      for (int k = 0; k < 8; k++) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        doTick(); advance();
        readReg(0, d); check("R12 random sec", d, enc(mSec));
      end
      checkAll(mBin ? "R4 R8 R9 random" : "R3 R6 R8 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule